// File: doc/BRIEF.md
# MSI Message Ring Collector

This block receives message-signalled interrupts, each carrying a 16-bit interrupt number, and stores every one as a 16-byte record in a circular buffer held in system memory. Software gives the buffer a 64-bit base address and picks one of four power-of-two sizes. It reads the producer offset to learn how far the hardware has written. After it consumes records, it writes back a consumer offset. An interrupt line stays high while unread records remain.

Each record goes out as a single request on a memory-write port. The request holds until the port acknowledges it. The producer offset moves only after that acknowledge, so software never sees a record announced before its data has landed. When full detection is on and the ring is full, the block does one of two things. It can hold off the inbound port until software frees a slot. Or it can drop the message and set a sticky overflow flag.

Top module: `msi_ring_collector`

## Requirements
- R1: After reset the control word, both offsets, `irq_out` and `mem_req` are zero, and `msg_ready` is low.
- R2: Register word addresses are control 0, base high 3, base low 4, consumer offset 5 and producer offset 6; other addresses read zero. Control bits: 0 enable, 1 full detection, 2 overflow flag, 3 interrupt enable, 4 stop-on-full, and 9:8 size code c, giving a ring of 2^(15+c) bytes. Bits that are not listed read zero. A consumer-offset write keeps only the bits that are multiples of 16 below the current ring size.
- R3: A record request carries address = {base high, base low} + producer offset. Its 128-bit data is little-endian: bits 15:0 hold the interrupt number and all other bits are zero.
- R4: `mem_req` is raised in the cycle after a message is accepted and holds with stable address and data until `mem_ack`. The producer offset advances by 16 only at the acknowledging edge.
- R5: The producer offset wraps to zero after the last 16-byte slot of the configured ring size.
- R6: With full detection and stop-on-full set, `msg_ready` is low while (producer + 16) mod size equals the consumer offset. It returns once software moves the consumer offset.
- R7: With full detection set and stop-on-full clear, a message that arrives when the ring is full is accepted and dropped. No request is issued, the producer offset is kept, and control bit 2 is set. Writing 1 to bit 2 clears the flag; writing 0 leaves it set.
- R8: With full detection clear, records are written even when the full condition holds.
- R9: `irq_out` is high one cycle after enable, interrupt enable and consumer != producer all hold, and low one cycle after any of them stops holding.
- R10: With enable clear, `msg_ready` is low and no record is written.
- R11: Software writes to the producer offset register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on address) |
| msg_valid | input | 1 | Inbound message valid |
| msg_num | input | 16 | Inbound interrupt number |
| msg_ready | output | 1 | Inbound message ready |
| mem_req | output | 1 | Record write request |
| mem_addr | output | 64 | Record byte address |
| mem_data | output | 128 | Record contents, little-endian |
| mem_ack | input | 1 | Record write acknowledge |
| irq_out | output | 1 | Interrupt line |

## Verification
A message is taken at the edge where `msg_valid` and `msg_ready` are both high. The request is visible at the following falling edge. The producer offset reads back advanced at the falling edge after the acknowledging rising edge. `irq_out` follows one further rising edge later. Register writes take effect at their rising edge, and reads are combinational. The bench therefore samples every result at a falling edge, at a count of rising edges derived from these latencies. It checks the interrupt both at the edge before it is due and at the edge where it is due. This catches an early change as well as a missing one.

// File: rtl/msi_ring_pkg.sv
package msi_ring_pkg;

  localparam int MIN_LOG   = 15;
  localparam int MAX_LOG   = 18;
  localparam int OFS_W     = MAX_LOG;
  localparam int REC_BYTES = 16;
  localparam int REC_W     = REC_BYTES * 8;
  localparam int ADDR_W    = 64;
  localparam int DATA_W    = 32;
  localparam int REG_AW    = 3;
  localparam int NUM_W     = 16;

  // control bit positions
  localparam int CB_EN   = 0;
  localparam int CB_FDET = 1;
  localparam int CB_OVF  = 2;
  localparam int CB_IE   = 3;
  localparam int CB_STOP = 4;
  localparam int CB_SZ   = 8;

  typedef enum logic [REG_AW-1:0] {
    RA_CTRL    = 3'd0,
    RA_BASE_HI = 3'd3,
    RA_BASE_LO = 3'd4,
    RA_CONS    = 3'd5,
    RA_PROD    = 3'd6
  } reg_addr_e;

  typedef struct packed {
    logic [1:0] size;
    logic       stop;
    logic       ie;
    logic       ovf;
    logic       fdet;
    logic       en;
  } ctrl_t;

  typedef enum logic {WS_IDLE, WS_BUSY} wstate_e;

  // mask that keeps slot-aligned offsets inside the selected ring size
  function automatic logic [OFS_W-1:0] slot_mask(input logic [1:0] code);
    logic [OFS_W:0] span;
    span = (OFS_W+1)'(1) << (MIN_LOG + int'(code));
    return OFS_W'(span - (OFS_W+1)'(1)) & ~OFS_W'(REC_BYTES - 1);
  endfunction

endpackage

// File: rtl/msi_ring_regs.sv
module msi_ring_regs
  import msi_ring_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              ovf_set,
  input  logic [OFS_W-1:0]  prod_ofs,
  output ctrl_t             ctrl_q,
  output logic [ADDR_W-1:0] base_q,
  output logic [OFS_W-1:0]  cons_q,
  output logic [DATA_W-1:0] reg_rdata
);

  ctrl_t             ctrl_d;
  logic [ADDR_W-1:0] base_d;
  logic [OFS_W-1:0]  cons_d;
  logic              wr_ctrl, wr_hi, wr_lo, wr_cons;

  always_comb begin
    wr_ctrl = reg_we && (reg_addr == RA_CTRL);
    wr_hi   = reg_we && (reg_addr == RA_BASE_HI);
    wr_lo   = reg_we && (reg_addr == RA_BASE_LO);
    wr_cons = reg_we && (reg_addr == RA_CONS);
  end

  // next state
  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d.en   = reg_wdata[CB_EN];
      ctrl_d.fdet = reg_wdata[CB_FDET];
      ctrl_d.ie   = reg_wdata[CB_IE];
      ctrl_d.stop = reg_wdata[CB_STOP];
      ctrl_d.size = reg_wdata[CB_SZ +: 2];
      if (reg_wdata[CB_OVF]) ctrl_d.ovf = 1'b0;
    end
    if (ovf_set) ctrl_d.ovf = 1'b1;

    base_d = base_q;
    if (wr_hi) base_d[ADDR_W-1:DATA_W] = reg_wdata;
    if (wr_lo) base_d[DATA_W-1:0]      = reg_wdata;

    cons_d = cons_q;
    if (wr_cons) cons_d = reg_wdata[OFS_W-1:0] & slot_mask(ctrl_q.size);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      base_q <= '0;
      cons_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      if (wr_hi || wr_lo) base_q <= base_d;
      if (wr_cons)        cons_q <= cons_d;
    end
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL: begin
        reg_rdata[CB_EN]      = ctrl_q.en;
        reg_rdata[CB_FDET]    = ctrl_q.fdet;
        reg_rdata[CB_OVF]     = ctrl_q.ovf;
        reg_rdata[CB_IE]      = ctrl_q.ie;
        reg_rdata[CB_STOP]    = ctrl_q.stop;
        reg_rdata[CB_SZ +: 2] = ctrl_q.size;
      end
      RA_BASE_HI: reg_rdata = base_q[ADDR_W-1:DATA_W];
      RA_BASE_LO: reg_rdata = base_q[DATA_W-1:0];
      RA_CONS:    reg_rdata = DATA_W'(cons_q);
      RA_PROD:    reg_rdata = DATA_W'(prod_ofs);
      default:    reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/msi_ring_writer.sv
module msi_ring_writer
  import msi_ring_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             ctrl,
  input  logic [ADDR_W-1:0] base,
  input  logic [OFS_W-1:0]  cons_ofs,
  input  logic              msg_valid,
  input  logic [NUM_W-1:0]  msg_num,
  output logic              msg_ready,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [REC_W-1:0]  mem_data,
  input  logic              mem_ack,
  output logic [OFS_W-1:0]  prod_q,
  output logic              ovf_set
);

  wstate_e           st_q, st_d;
  logic [OFS_W-1:0]  prod_d;
  logic [NUM_W-1:0]  num_q, num_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [OFS_W-1:0]  next_slot;
  logic              full, blocked, accept;

  always_comb begin
    next_slot = (prod_q + OFS_W'(REC_BYTES)) & slot_mask(ctrl.size);
    full      = (next_slot == cons_ofs);
    blocked   = ctrl.fdet && full;
    msg_ready = (st_q == WS_IDLE) && ctrl.en && !(blocked && ctrl.stop);
    accept    = msg_valid && msg_ready;
  end

  // next state
  always_comb begin
    st_d    = st_q;
    prod_d  = prod_q;
    num_d   = num_q;
    addr_d  = addr_q;
    ovf_set = 1'b0;
    case (st_q)
      WS_IDLE: begin
        if (accept) begin
          if (blocked) begin
            ovf_set = 1'b1;
          end else begin
            st_d   = WS_BUSY;
            num_d  = msg_num;
            addr_d = base + ADDR_W'(prod_q);
          end
        end
      end
      WS_BUSY: begin
        if (mem_ack) begin
          prod_d = next_slot;
          st_d   = WS_IDLE;
        end
      end
      default: st_d = WS_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WS_IDLE;
      prod_q <= '0;
      num_q  <= '0;
      addr_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == WS_BUSY && mem_ack) prod_q <= prod_d;
      if (st_q == WS_IDLE && accept) begin
        num_q  <= num_d;
        addr_q <= addr_d;
      end
    end
  end

  always_comb begin
    mem_req  = (st_q == WS_BUSY);
    mem_addr = addr_q;
    mem_data = {{(REC_W-NUM_W){1'b0}}, num_q};
  end

endmodule

// File: rtl/msi_ring_irq.sv
module msi_ring_irq
  import msi_ring_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             ie,
  input  logic [OFS_W-1:0] cons_ofs,
  input  logic [OFS_W-1:0] prod_ofs,
  output logic             irq_q
);

  logic irq_d;

  always_comb irq_d = en && ie && (cons_ofs != prod_ofs);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

endmodule

// File: rtl/msi_ring_collector.sv
module msi_ring_collector
  import msi_ring_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              msg_valid,
  input  logic [NUM_W-1:0]  msg_num,
  output logic              msg_ready,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [REC_W-1:0]  mem_data,
  input  logic              mem_ack,
  output logic              irq_out
);

  logic [1:0]        rst_sync;
  logic              rst_n_int;
  ctrl_t             ctrl_q;
  logic [ADDR_W-1:0] base_q;
  logic [OFS_W-1:0]  cons_ofs, prod_ofs;
  logic              ovf_set;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_int = rst_sync[1];

  msi_ring_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .ovf_set   (ovf_set),
    .prod_ofs  (prod_ofs),
    .ctrl_q    (ctrl_q),
    .base_q    (base_q),
    .cons_q    (cons_ofs),
    .reg_rdata (reg_rdata)
  );

  msi_ring_writer u_writer (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .ctrl      (ctrl_q),
    .base      (base_q),
    .cons_ofs  (cons_ofs),
    .msg_valid (msg_valid),
    .msg_num   (msg_num),
    .msg_ready (msg_ready),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data),
    .mem_ack   (mem_ack),
    .prod_q    (prod_ofs),
    .ovf_set   (ovf_set)
  );

  msi_ring_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .en       (ctrl_q.en),
    .ie       (ctrl_q.ie),
    .cons_ofs (cons_ofs),
    .prod_ofs (prod_ofs),
    .irq_q    (irq_out)
  );

endmodule

// File: rtl/msi_ring_collector_chk.sv
module msi_ring_collector_chk
  import msi_ring_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input ctrl_t             ctrl,
  input logic [OFS_W-1:0]  prod_ofs,
  input logic [OFS_W-1:0]  cons_ofs,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [REC_W-1:0]  mem_data,
  input logic              mem_ack,
  input logic              irq_out
);

  logic [OFS_W:0] ring_bytes;
  logic           full_ref;
  logic           irq_cond;

  always_comb begin
    ring_bytes = (OFS_W+1)'(32768) << ctrl.size;
    full_ref   = ((({1'b0, prod_ofs} + (OFS_W+1)'(16)) % ring_bytes) == {1'b0, cons_ofs});
    irq_cond   = ctrl.en && ctrl.ie && (prod_ofs != cons_ofs);
  end

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_data)));

  // R4
  prod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ack |=> $stable(prod_ofs));

  // R3
  data_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_data[REC_W-1:NUM_W] == '0));

  // R5
  ofs_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_ofs[3:0] == 4'd0) && (cons_ofs[3:0] == 4'd0));

  // R6
  stop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.fdet && ctrl.stop && full_ref) |-> !msg_ready);

  // R7
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready && ctrl.fdet && !ctrl.stop && full_ref) |=> (ctrl.ovf && !mem_req));

  // R9
  irq_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cond |=> irq_out);

  // R9
  irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_cond |=> !irq_out);

  // R10
  dis_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.en |-> !msg_ready);

endmodule

bind msi_ring_collector msi_ring_collector_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n_int),
  .ctrl      (ctrl_q),
  .prod_ofs  (prod_ofs),
  .cons_ofs  (cons_ofs),
  .msg_valid (msg_valid),
  .msg_ready (msg_ready),
  .mem_req   (mem_req),
  .mem_addr  (mem_addr),
  .mem_data  (mem_data),
  .mem_ack   (mem_ack),
  .irq_out   (irq_out)
);

// File: tb/msi_ring_collector_test.sv
`timescale 1ns/1ps
module msi_ring_collector_test;

  logic         clk;
  logic         rst_n;
  logic         reg_we;
  logic [2:0]   reg_addr;
  logic [31:0]  reg_wdata;
  logic [31:0]  reg_rdata;
  logic         msg_valid;
  logic [15:0]  msg_num;
  logic         msg_ready;
  logic         mem_req;
  logic [63:0]  mem_addr;
  logic [127:0] mem_data;
  logic         mem_ack;
  logic         irq_out;

  int nchk  = 0;
  int nfail = 0;

  logic [63:0]  obs_addr;
  logic [127:0] obs_data;
  logic         obs_req;
  logic [31:0]  obs_prod_wait;

  localparam logic [63:0] BASE = 64'h0000_0001_8000_0000;

  msi_ring_collector uut (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .msg_valid(msg_valid), .msg_num(msg_num), .msg_ready(msg_ready),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data), .mem_ack(mem_ack),
    .irq_out(irq_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // offer one message; acknowledge its record after dly cycles
  task automatic push(input logic [15:0] num, input int dly, output bit took);
    logic rdy;
    took = 1'b0;
    msg_valid = 1'b1; msg_num = num;
    for (int i = 0; i < 20; i++) begin
      #1; rdy = msg_ready;
      @(posedge clk); @(negedge clk);
      if (rdy) begin took = 1'b1; break; end
    end
    msg_valid = 1'b0;
    obs_req  = mem_req;
    obs_addr = mem_addr;
    obs_data = mem_data;
    if (took && mem_req) begin
      for (int i = 0; i < dly; i++) begin @(posedge clk); @(negedge clk); end
      reg_read(3'd6, obs_prod_wait);
      chk("R4 request still held", {127'd0, mem_req}, 128'd1);
      mem_ack = 1'b1;
      @(posedge clk); @(negedge clk);
      mem_ack = 1'b0;
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    reg_read(3'd0, v); chk("R1 control", v, 0);
    reg_read(3'd5, v); chk("R1 consumer", v, 0);
    reg_read(3'd6, v); chk("R1 producer", v, 0);
    chk("R1 irq", irq_out, 0);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 ready", msg_ready, 0);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    reg_write(3'd3, BASE[63:32]);
    reg_write(3'd4, BASE[31:0]);
    reg_read(3'd3, v); chk("R2 base high", v, BASE[63:32]);
    reg_read(3'd4, v); chk("R2 base low", v, BASE[31:0]);
    reg_write(3'd0, 32'h0000_FFE9);
    reg_read(3'd0, v); chk("R2 control fields", v, 32'h0000_0309);
    reg_write(3'd0, 32'h0000_010D);
    reg_read(3'd0, v); chk("R2 control, flag clear stays clear", v, 32'h0000_0109);
    reg_write(3'd5, 32'h1234_5678);
    reg_read(3'd5, v); chk("R2 consumer masked to 64KiB", v, 32'h0000_5670);
    reg_read(3'd2, v); chk("R2 unmapped address", v, 0);
    reg_write(3'd5, 32'h0);
    reg_write(3'd6, 32'h0000_0100);
    reg_read(3'd6, v); chk("R11 producer write ignored", v, 0);
  endtask

  task automatic t_record;
    logic [31:0] v;
    bit took;
    push(16'hBEEF, 3, took);
    chk("R3 first address", obs_addr, BASE);
    chk("R3 first data", obs_data, 128'h0000_BEEF);
    chk("R4 producer before ack", obs_prod_wait, 0);
    reg_read(3'd6, v); chk("R4 producer after ack", v, 32'h10);
    chk("R9 irq not yet", irq_out, 0);
    @(posedge clk); @(negedge clk);
    chk("R9 irq raised", irq_out, 1);
    push(16'hFFFF, 0, took);
    chk("R3 second address", obs_addr, BASE + 64'h10);
    chk("R3 second data", obs_data, 128'h0000_FFFF);
    reg_read(3'd6, v); chk("R4 producer second", v, 32'h20);
    reg_write(3'd5, 32'h20);
    chk("R9 irq held one cycle", irq_out, 1);
    @(posedge clk); @(negedge clk);
    chk("R9 irq dropped", irq_out, 0);
  endtask

  task automatic t_full_stop;
    logic [31:0] v;
    bit took;
    reg_write(3'd0, 32'h0000_001B);
    reg_write(3'd5, 32'h40);
    push(16'h0101, 1, took);
    chk("R6 record before full", {127'd0, obs_req}, 1);
    reg_read(3'd6, v); chk("R6 producer at full", v, 32'h30);
    msg_valid = 1'b1; msg_num = 16'h0202;
    for (int i = 0; i < 5; i++) begin
      #1;
      chk("R6 ready low when full", msg_ready, 0);
      chk("R6 no request when full", mem_req, 0);
      @(posedge clk); @(negedge clk);
    end
    reg_write(3'd5, 32'h50);
    #1; chk("R6 ready back", msg_ready, 1);
    push(16'h0202, 0, took);
    chk("R6 held message written", obs_addr, BASE + 64'h30);
    reg_read(3'd6, v); chk("R6 producer after resume", v, 32'h40);
  endtask

  task automatic t_full_drop;
    logic [31:0] v;
    bit took;
    reg_write(3'd0, 32'h0000_000B);
    push(16'h0777, 0, took);
    chk("R7 message accepted", {127'd0, took}, 1);
    chk("R7 no request on drop", {127'd0, obs_req}, 0);
    reg_read(3'd6, v); chk("R7 producer kept", v, 32'h40);
    reg_read(3'd0, v); chk("R7 flag set", v, 32'h0F);
    reg_write(3'd0, 32'h0000_000B);
    reg_read(3'd0, v); chk("R7 writing 0 keeps flag", v, 32'h0F);
    reg_write(3'd0, 32'h0000_000F);
    reg_read(3'd0, v); chk("R7 writing 1 clears flag", v, 32'h0B);
  endtask

  task automatic t_no_detect;
    logic [31:0] v;
    bit took;
    reg_write(3'd0, 32'h0000_0009);
    push(16'h0222, 2, took);
    chk("R8 written despite full", {127'd0, obs_req}, 1);
    chk("R8 address", obs_addr, BASE + 64'h40);
    reg_read(3'd6, v); chk("R8 producer", v, 32'h50);
  endtask

  task automatic t_wrap;
    logic [31:0] v;
    bit took;
    reg_write(3'd0, 32'h0000_0001);
    for (int i = 0; i < 2043; i++) push(16'(i), 0, took);
    chk("R5 last slot address", obs_addr, BASE + 64'h7FF0);
    reg_read(3'd6, v); chk("R5 producer wrapped", v, 0);
    chk("R9 irq off without interrupt enable", irq_out, 0);
  endtask

  task automatic t_disable;
    logic [31:0] v;
    reg_write(3'd0, 32'h0000_0009);
    @(posedge clk); @(negedge clk);
    chk("R9 irq with pending records", irq_out, 1);
    reg_write(3'd0, 32'h0);
    @(posedge clk); @(negedge clk);
    chk("R10 irq dropped when disabled", irq_out, 0);
    msg_valid = 1'b1; msg_num = 16'h0999;
    for (int i = 0; i < 4; i++) begin
      #1;
      chk("R10 ready low", msg_ready, 0);
      chk("R10 no request", mem_req, 0);
      @(posedge clk); @(negedge clk);
    end
    msg_valid = 1'b0;
    reg_read(3'd6, v); chk("R10 producer unchanged", v, 0);
  endtask

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    msg_valid = 1'b0; msg_num = '0; mem_ack = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_regs();
    t_record();
    t_full_stop();
    t_full_drop();
    t_no_detect();
    t_wrap();
    t_disable();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule